// File: doc/BRIEF.md
# ADC Command Sequencer with External Trigger

This block is the digital control core of a 24-input successive-approximation converter. It takes 16-bit command words that a serial front end has already assembled. From each word it picks an operation and a channel, then drives the channel multiplexer select and the trial code for an external DAC and comparator. It resolves a 10-bit result one bit per clock, starting at the MSB. When a conversion ends it raises a completion flag, drives an active-low interrupt, and presents a 16-bit result word for the serial shifter to send.

Four operations are supported. A one-shot conversion runs once. An armed conversion waits for a filtered rising edge on a trigger pin and stays armed while only no-op words follow. A no-op changes nothing. A halt aborts any activity. Any non-no-op word cancels whatever is running. One channel code samples eight digital pins in place of a conversion. Every reserved operation or channel code behaves as a halt.

The state machine has five states. ST_IDLE waits for a command. ST_ARMED waits for a trigger edge. ST_SAMPLE holds the input for SAMPLE_CYC cycles. ST_CONVERT runs the bit trials. ST_PORT counts PORT_CYC cycles, then latches the pins. The transitions are as follows:
- A halt word moves any state to ST_IDLE.
- A one-shot word moves any state to ST_SAMPLE, or to ST_PORT for the pin-sample code.
- An armed word moves any state to ST_ARMED.
- A trigger edge moves ST_ARMED to ST_SAMPLE.
- ST_SAMPLE moves to ST_CONVERT once its count is reached.
- ST_CONVERT moves to ST_ARMED (armed mode) or to ST_IDLE (one-shot) after the last bit.
- ST_PORT moves to ST_IDLE after its count.

Top module: `adc_cmd_seq`

## Requirements
- R1: After reset, endc=0, irq_n=1, result=0000h and sar_code=0.
- R2: A command word splits into operation bits 15:13 and channel bits 12:8. Bits 7:0 have no effect on the result.
- R3: Operation 001 with channel 0..23 converts that channel. chan_sel shows the channel. cmp_in=1 means the input is at or above sar_code and keeps the trial bit. The result is {code[9:0], 1, channel[4:0]}. endc rises SAMPLE_CYC+10 clocks after the command is accepted, which is at most 50.
- R4: irq_n is always the inverse of endc. result reads 0000h while endc=0. A result_read pulse clears endc.
- R5: A one-shot command during a conversion cancels it, clears endc and converts the new channel.
- R6: A no-op (operation 100) during a conversion leaves it and its result unchanged.
- R7: Halt (000), reserved operations 010, 011, 110 and 111, and channel codes 25..31 all abort activity. They leave endc=0 and sar_code=0.
- R8: Operation 001 with channel 24 samples port_pins after exactly PORT_CYC=10 clocks. The result is {port_pins[7:0], 00, 1, 11000}, where pin bit 7 stands for input 23.
- R9: Operation 101 combined with channel 24 acts as a halt, and trigger edges then start nothing.
- R10: Operation 101 with channel 0..23 arms the block. Conversion starts only on a rising edge of trig_in that has held for two consecutive samples, taken every TICK_CYC clocks.
- R11: Trigger edges that occur while a conversion runs are ignored.
- R12: In armed mode a later no-op keeps the block armed on the same channel, while a halt disarms it.
- R13: A conversion that ends while rx_active=1 raises endc only in the clock after rx_active falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe: cmd_word holds a complete command |
| cmd_word | input | 16 | Received command word |
| rx_active | input | 1 | A serial frame is currently being received |
| result_read | input | 1 | One-cycle strobe: the result has been shifted out |
| trig_in | input | 1 | External conversion trigger |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above sar_code |
| port_pins | input | 8 | Digital levels of inputs 23..16 (bit 7 = input 23) |
| chan_sel | output | 5 | Multiplexer channel select |
| sar_code | output | 10 | Trial code for the DAC, zero outside conversion |
| endc | output | 1 | Conversion-complete flag |
| irq_n | output | 1 | Active-low completion interrupt |
| result | output | 16 | Result word, zero while endc is low |

## Verification
The hardest case to reach from the ports is a trigger edge that falls inside a running conversion. The trigger is filtered and sampled coarsely, so the edge has to be timed against a conversion that was itself started by a trigger. The bench therefore uses a short sample interval and a long sampling phase. It drops and raises the trigger shortly after the first edge. It confirms that endc is still low at that moment, then checks that only one result ever appears. The deferred flag during a frame in progress is reached by holding rx_active high across the whole conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_BITS  = 10;
    localparam int CH_W      = 5;
    localparam int WORD_W    = 16;
    localparam int PIN_W     = 8;
    localparam int NUM_AN    = 24;
    localparam logic [CH_W-1:0] PIN_CODE = 5'd24;

    localparam logic [2:0] OPC_HALT   = 3'b000;
    localparam logic [2:0] OPC_SINGLE = 3'b001;
    localparam logic [2:0] OPC_NOP    = 3'b100;
    localparam logic [2:0] OPC_ARM    = 3'b101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SAMPLE,
        ST_CONVERT,
        ST_PORT
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_HALT,
        OP_SINGLE,
        OP_KEEP,
        OP_ARM
    } seq_op_t;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import adc_seq_pkg::*;
(
    input  logic [7:0]      hi_byte,
    output seq_op_t         op,
    output logic [CH_W-1:0] chan,
    output logic            pin_mode
);
    logic [2:0] opc;

    assign opc  = hi_byte[7:5];
    assign chan = hi_byte[4:0];

    always_comb begin
        op       = OP_HALT;
        pin_mode = 1'b0;
        unique case (opc)
            OPC_SINGLE: begin
                if (chan < CH_W'(NUM_AN)) begin
                    op = OP_SINGLE;
                end else if (chan == PIN_CODE) begin
                    op       = OP_SINGLE;
                    pin_mode = 1'b1;
                end
            end
            OPC_ARM: begin
                if (chan < CH_W'(NUM_AN)) op = OP_ARM;
            end
            OPC_NOP: op = OP_KEEP;
            default: op = OP_HALT;
        endcase
    end
endmodule

// File: rtl/trig_filter.sv
module trig_filter #(
    parameter int TICK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic rise
);
    localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

    logic [1:0]    sync_q;
    logic [TW-1:0] tick_cnt;
    logic          tick;
    logic          samp_q;
    logic          lvl_q;

    assign tick = (tick_cnt == TW'(TICK_CYC - 1));
    assign rise = tick && sync_q[1] && samp_q && !lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q   <= 2'b00;
            tick_cnt <= '0;
            samp_q   <= 1'b0;
            lvl_q    <= 1'b0;
        end else begin
            sync_q   <= {sync_q[0], trig_in};
            tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
            if (tick) begin
                samp_q <= sync_q[1];
                if (sync_q[1] == samp_q) lvl_q <= sync_q[1];
            end
        end
    end

    // R10
    rise_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> lvl_q);
endmodule

// File: rtl/sar_core.sv
module sar_core #(
    parameter int BITS = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    step,
    input  logic [$clog2(BITS)-1:0] idx,
    input  logic                    cmp_in,
    output logic [BITS-1:0]         trial,
    output logic [BITS-1:0]         acc_next
);
    logic [BITS-1:0] acc_q;

    assign trial    = acc_q | (BITS'(1) << idx);
    assign acc_next = cmp_in ? trial : acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else if (step)     acc_q <= acc_next;
    end
endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_CYC = 4,
    parameter int PORT_CYC   = 10,
    parameter int TICK_CYC   = 200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [WORD_W-1:0]   cmd_word,
    input  logic                rx_active,
    input  logic                result_read,
    input  logic                trig_in,
    input  logic                cmp_in,
    input  logic [PIN_W-1:0]    port_pins,
    output logic [CH_W-1:0]     chan_sel,
    output logic [RES_BITS-1:0] sar_code,
    output logic                endc,
    output logic                irq_n,
    output logic [WORD_W-1:0]   result
);
    localparam int MAX_CNT = (SAMPLE_CYC > PORT_CYC) ?
                             ((SAMPLE_CYC > RES_BITS) ? SAMPLE_CYC : RES_BITS) :
                             ((PORT_CYC > RES_BITS) ? PORT_CYC : RES_BITS);
    localparam int CNT_W = $clog2(MAX_CNT + 1);
    localparam int IW    = $clog2(RES_BITS);

    seq_state_t          st_q, st_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [CH_W-1:0]     chan_q, chan_d;
    logic                arm_q, arm_d;
    logic [WORD_W-1:0]   word_q, word_d;
    logic                endc_q, pend_q;
    logic                clr_flag, done, sar_clr, sar_step;

    seq_op_t             dec_op;
    logic [CH_W-1:0]     dec_chan;
    logic                dec_pin;
    logic                trig_rise;
    logic [RES_BITS-1:0] trial, acc_next;
    logic                unused_low;

    assign unused_low = ^cmd_word[7:0];

    cmd_decode u_dec (
        .hi_byte (cmd_word[15:8]),
        .op      (dec_op),
        .chan    (dec_chan),
        .pin_mode(dec_pin)
    );

    trig_filter #(.TICK_CYC(TICK_CYC)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_in(trig_in),
        .rise   (trig_rise)
    );

    sar_core #(.BITS(RES_BITS)) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sar_clr),
        .step    (sar_step),
        .idx     (cnt_q[IW-1:0]),
        .cmp_in  (cmp_in),
        .trial   (trial),
        .acc_next(acc_next)
    );

    // next-state and datapath control
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        chan_d   = chan_q;
        arm_d    = arm_q;
        word_d   = word_q;
        clr_flag = 1'b0;
        done     = 1'b0;
        sar_clr  = 1'b0;
        sar_step = 1'b0;
        if (cmd_valid && dec_op != OP_KEEP) begin
            clr_flag = 1'b1;
            unique case (dec_op)
                OP_SINGLE: begin
                    chan_d  = dec_chan;
                    arm_d   = 1'b0;
                    cnt_d   = '0;
                    sar_clr = 1'b1;
                    st_d    = dec_pin ? ST_PORT : ST_SAMPLE;
                end
                OP_ARM: begin
                    chan_d = dec_chan;
                    arm_d  = 1'b1;
                    st_d   = ST_ARMED;
                end
                default: begin
                    arm_d = 1'b0;
                    st_d  = ST_IDLE;
                end
            endcase
        end else begin
            unique case (st_q)
                ST_IDLE: ;
                ST_ARMED: begin
                    if (trig_rise) begin
                        st_d     = ST_SAMPLE;
                        cnt_d    = '0;
                        sar_clr  = 1'b1;
                        clr_flag = 1'b1;
                    end
                end
                ST_SAMPLE: begin
                    if (cnt_q == CNT_W'(SAMPLE_CYC - 1)) begin
                        st_d  = ST_CONVERT;
                        cnt_d = CNT_W'(RES_BITS - 1);
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_CONVERT: begin
                    sar_step = 1'b1;
                    if (cnt_q == '0) begin
                        done   = 1'b1;
                        word_d = {acc_next, 1'b0, chan_q};
                        st_d   = arm_q ? ST_ARMED : ST_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_PORT: begin
                    if (cnt_q == CNT_W'(PORT_CYC - 1)) begin
                        done   = 1'b1;
                        word_d = {port_pins, 2'b00, 1'b0, PIN_CODE};
                        st_d   = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            chan_q <= '0;
            arm_q  <= 1'b0;
            word_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            chan_q <= chan_d;
            arm_q  <= arm_d;
            word_q <= word_d;
        end
    end

    // completion flag, held back while a frame is arriving
    always_ff @(posedge clk) begin
        if (!rst_n || clr_flag || result_read) begin
            endc_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (done || pend_q) begin
            if (rx_active) begin
                pend_q <= 1'b1;
            end else begin
                endc_q <= 1'b1;
                pend_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        chan_sel = chan_q;
        sar_code = (st_q == ST_CONVERT) ? trial : '0;
        endc     = endc_q;
        irq_n    = !endc_q;
        result   = endc_q ? (word_q | WORD_W'(16'h0020)) : '0;
    end

    // R7
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && dec_op == OP_HALT) |=> (st_q == ST_IDLE && !endc_q));
    // R3
    trial_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CONVERT) |-> (sar_code != '0));
    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_read |=> !endc_q);
    // R13
    defer_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(endc_q) |-> !$past(rx_active));
    // R6
    nop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && dec_op == OP_KEEP && st_q == ST_CONVERT && cnt_q != '0)
        |=> (st_q == ST_CONVERT));
    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SAMPLE && !cmd_valid) |=> (st_q == ST_SAMPLE || st_q == ST_CONVERT));
endmodule

// File: tb/sim_adc_cmd_seq.sv
module sim_adc_cmd_seq;
    localparam int SCYC = 20;
    localparam int TCYC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        rx_active = 1'b0;
    logic        result_read = 1'b0;
    logic        trig_in = 1'b0;
    logic        cmp_in;
    logic [7:0]  port_pins = 8'h00;
    logic [4:0]  chan_sel;
    logic [9:0]  sar_code;
    logic        endc, irq_n;
    logic [15:0] result;

    logic [9:0]  vin [24];
    int          errors = 0;
    int          checks = 0;

    always #2.5 clk = ~clk;

    assign cmp_in = (chan_sel < 5'd24) ? (vin[chan_sel] >= sar_code) : 1'b0;

    adc_cmd_seq #(.SAMPLE_CYC(SCYC), .PORT_CYC(10), .TICK_CYC(TCYC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .rx_active(rx_active), .result_read(result_read), .trig_in(trig_in),
        .cmp_in(cmp_in), .port_pins(port_pins), .chan_sel(chan_sel),
        .sar_code(sar_code), .endc(endc), .irq_n(irq_n), .result(result)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_word  = w;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_endc(input int max, output int n);
        n = 0;
        while (!endc && n < max) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_read();
        @(negedge clk);
        result_read = 1'b1;
        @(negedge clk);
        result_read = 1'b0;
    endtask

    function automatic logic [15:0] conv_word(input int ch);
        return {vin[ch], 1'b1, 5'(ch)};
    endfunction

    task automatic t_reset();
        check("R1 endc", endc, 0);
        check("R1 irq_n", irq_n, 1);
        check("R1 result", result, 0);
        check("R1 sar_code", sar_code, 0);
    endtask

    task automatic t_single(input int ch, input logic [7:0] junk);
        int n;
        send({3'b001, 5'(ch), junk});
        check("R3 chan_sel", chan_sel, ch);
        wait_endc(100, n);
        check("R3 latency", n, SCYC + 10);
        check("R3 result", result, conv_word(ch));
        check("R2 low bits ignored", result, conv_word(ch));
        check("R4 irq_n low", irq_n, 0);
        do_read();
        check("R4 endc cleared", endc, 0);
        check("R4 result zero", result, 0);
        check("R4 irq_n high", irq_n, 1);
    endtask

    task automatic t_cancel();
        int n;
        send({3'b001, 5'd3, 8'h00});
        idle(5);
        send({3'b001, 5'd7, 8'h00});
        wait_endc(100, n);
        check("R5 new channel result", result, conv_word(7));
        do_read();
    endtask

    task automatic t_nop();
        int n;
        send({3'b001, 5'd9, 8'h00});
        idle(SCYC + 3);
        send({3'b100, 5'd2, 8'h00});
        wait_endc(100, n);
        check("R6 nop no effect", result, conv_word(9));
        do_read();
    endtask

    task automatic t_stop(input logic [15:0] w, input string tag);
        send({3'b001, 5'd4, 8'h00});
        idle(SCYC + 2);
        send(w);
        idle(60);
        check({"R7 endc ", tag}, endc, 0);
        check({"R7 sar_code ", tag}, sar_code, 0);
    endtask

    task automatic t_port();
        int n;
        port_pins = 8'hC5;
        send({3'b001, 5'd24, 8'h00});
        wait_endc(100, n);
        check("R8 latency", n, 10);
        check("R8 result", result, 16'hC538);
        do_read();
    endtask

    task automatic t_port_arm();
        send({3'b101, 5'd24, 8'h00});
        trig_in = 1'b1;
        idle(60);
        check("R9 no conversion", endc, 0);
        check("R9 sar idle", sar_code, 0);
        trig_in = 1'b0;
        idle(20);
    endtask

    task automatic t_trig();
        int n;
        send({3'b101, 5'd5, 8'h00});
        idle(40);
        check("R10 waits for edge", endc, 0);
        trig_in = 1'b1;
        wait_endc(100, n);
        check("R10 triggered result", result, conv_word(5));
        do_read();
        idle(60);
        check("R10 level is not an edge", endc, 0);
        trig_in = 1'b0;
        idle(20);
    endtask

    task automatic t_busy_edge();
        int n;
        send({3'b101, 5'd6, 8'h00});
        idle(4);
        trig_in = 1'b1;
        idle(10);
        trig_in = 1'b0;
        idle(8);
        trig_in = 1'b1;
        check("R11 edge inside conversion", endc, 0);
        wait_endc(100, n);
        check("R11 first result", result, conv_word(6));
        do_read();
        idle(80);
        check("R11 busy edge ignored", endc, 0);
    endtask

    task automatic t_rearm();
        int n;
        send({3'b100, 5'd1, 8'h00});
        trig_in = 1'b0;
        idle(12);
        trig_in = 1'b1;
        wait_endc(100, n);
        check("R12 re-armed same channel", result, conv_word(6));
        do_read();
        send({3'b000, 5'd0, 8'h00});
        trig_in = 1'b0;
        idle(12);
        trig_in = 1'b1;
        idle(80);
        check("R12 halt disarms", endc, 0);
        trig_in = 1'b0;
        idle(20);
    endtask

    task automatic t_defer();
        send({3'b001, 5'd11, 8'h00});
        rx_active = 1'b1;
        idle(SCYC + 30);
        check("R13 held during frame", endc, 0);
        check("R13 irq_n held", irq_n, 1);
        rx_active = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R13 raised after frame", endc, 1);
        check("R13 result", result, conv_word(11));
        do_read();
    endtask

    initial begin
        for (int i = 0; i < 24; i++) vin[i] = 10'((i * 41 + 7) % 1024);
        vin[0]  = 10'h000;
        vin[23] = 10'h3FF;
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_single(0, 8'h00);
        t_single(13, 8'hA5);
        t_single(23, 8'hFF);
        t_cancel();
        t_nop();
        t_stop({3'b000, 5'd4, 8'h00}, "halt");
        t_stop({3'b011, 5'd4, 8'h00}, "op011");
        t_stop({3'b010, 5'd4, 8'h00}, "op010");
        t_stop({3'b110, 5'd4, 8'h00}, "op110");
        t_stop({3'b111, 5'd4, 8'h00}, "op111");
        t_stop({3'b001, 5'd26, 8'h00}, "chan26");
        t_port();
        t_port_arm();
        t_trig();
        t_busy_edge();
        t_rearm();
        t_defer();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule